// File: doc/BRIEF.md
# Sleep and Standby Power-Mode Sequencer

This block decides whether a processor runs, sleeps or stands by. A pulse from the core says that a sleep instruction has retired. A standby-select bit, written by the core and held here, picks the low-power mode that the pulse enters. Sleep halts only the CPU. Peripheral clocks and the external clock outputs keep running, so on-chip peripherals can go on working and raise the interrupt that ends the sleep. Standby stops every clock the block controls. On entry to standby it also sends a one-cycle initialisation pulse to the peripherals that lose their state.

Five interrupt classes end either low-power mode: non-maskable, external request lines, an encoded level input, on-chip peripheral lines and a port interrupt. The core's block-interrupts bit has no effect on this. When the block wakes, it raises a one-cycle wake strobe with a code that names the winning source, and the exception logic uses that code. A wake from standby first waits a programmable number of cycles for the oscillator to settle. A manual reset returns the block to run from any mode. A power-on reset does the same asynchronously and also clears the standby-select bit. Two status pins show the current mode.

Top module: `pm_power_ctrl`

## Requirements
- R1: In run mode, a sleep pulse with the standby-select bit at 0 causes the following cycle to show the sleep state: status pins 2'b10 and the CPU halted.
- R2: During sleep, the peripheral clock enable and the external clock-output enable both stay at 1, the CPU halt stays at 1 and the status pins read 2'b10.
- R3: In run mode, the status pins read 2'b00, the CPU halt is 0 and both clock enables are 1. After power-on reset the block is in run mode, with the wake strobe and the initialisation pulse at 0.
- R4: During sleep, a request at a clock edge returns the block to run in the next cycle and raises the wake strobe for exactly that one cycle. A request is NMI high, any external request line high, a nonzero encoded level, any peripheral line high or the port line high. The block-interrupts input has no effect on this.
- R5: Wake-code priority, from highest to lowest: NMI gives 8'h01. A nonzero level L gives 8'h10+L. External line i gives 8'h20+i, and the lowest index wins. Peripheral line j gives 8'h40+j, and the lowest index wins. The port line gives 8'h80.
- R6: In run mode, a sleep pulse with the standby-select bit at 1 enters standby. Status reads 2'b11, the CPU is halted, both clock enables are 0, and the initialisation pulse is 1 for the first standby cycle only.
- R7: During standby, a request at an edge keeps status 2'b11 with all clocks off for settle_cyc+1 further cycles. The block then returns to run with a one-cycle wake strobe, and the code is the one chosen at the accepting edge.
- R8: Outside run mode, the sleep pulse is ignored. Sleep and standby stay as they are when no request is present.
- R9: A manual reset pulse returns the block to run at the next edge from any mode, with no wake strobe, and leaves the standby-select bit unchanged.
- R10: Power-on reset acts asynchronously. It forces run mode and clears the standby-select bit to 0.
- R11: A write strobe loads the standby-select bit from its data input. The new value appears on stby_sel in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst | input | 1 | Manual reset pulse, synchronous, active high |
| sleep_exec | input | 1 | One-cycle pulse: sleep instruction retired |
| sel_we | input | 1 | Write strobe for the standby-select bit |
| sel_d | input | 1 | Data for the standby-select bit |
| settle_cyc | input | SETTLE_W | Oscillator settle wait, in cycles minus one |
| intr_blk | input | 1 | Core block-interrupts bit; does not affect wake-up |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | N_IRQ | External interrupt request lines |
| irl | input | IRL_W | Encoded level interrupt; zero means none |
| peri_irq | input | N_PERI | On-chip peripheral interrupt lines |
| port_irq | input | 1 | Port interrupt request |
| cpu_halt | output | 1 | CPU halted |
| pclk_en | output | 1 | Peripheral clock enable |
| ckout_en | output | 1 | Enable for both external clock outputs |
| stat_pins | output | 2 | Mode code: 00 run, 10 sleep, 11 standby |
| wake_vld | output | 1 | One-cycle wake strobe |
| wake_code | output | 8 | Source code of the last wake |
| pinit_pulse | output | 1 | Peripheral initialisation pulse on standby entry |
| stby_sel | output | 1 | Current standby-select bit |

## Verification
The hardest case to reach from the ports is the tail of the standby exit. A request must be caught while every clock enable is low, and the block must then hold off for exactly the programmed settle time before the wake strobe appears. The stimulus writes the select bit, enters standby and fires a single peripheral line for one cycle. It then checks status and enables at every cycle of the wait, for both a nonzero settle value and a zero one. Manual and power-on resets are also applied during standby to check that no wake strobe escapes and that the select bit is kept or cleared as R9 and R10 require.

// File: rtl/pm_pkg.sv
package pm_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_SLEEP  = 2'd1,
      PM_STBY   = 2'd2,
      PM_SETTLE = 2'd3
   } pm_mode_e;

   localparam int WCODE_W = 8;

   localparam logic [1:0] STAT_RUN   = 2'b00;
   localparam logic [1:0] STAT_SLEEP = 2'b10;
   localparam logic [1:0] STAT_STBY  = 2'b11;

   localparam logic [WCODE_W-1:0] WC_NMI       = 8'h01;
   localparam logic [WCODE_W-1:0] WC_IRL_BASE  = 8'h10;
   localparam logic [WCODE_W-1:0] WC_IRQ_BASE  = 8'h20;
   localparam logic [WCODE_W-1:0] WC_PERI_BASE = 8'h40;
   localparam logic [WCODE_W-1:0] WC_PORT      = 8'h80;

endpackage

// File: rtl/pm_wake_enc.sv
module pm_wake_enc
   import pm_pkg::*;
#(
   parameter int N_IRQ  = 8,
   parameter int N_PERI = 16,
   parameter int IRL_W  = 4
)(
   input  logic               nmi,
   input  logic [N_IRQ-1:0]   irq,
   input  logic [IRL_W-1:0]   irl,
   input  logic [N_PERI-1:0]  peri_irq,
   input  logic               port_irq,
   output logic               req,
   output logic [WCODE_W-1:0] code
);

   localparam int IRQ_MAX  = 16;
   localparam int PERI_MAX = 32;

   if (N_IRQ < 1 || N_IRQ > IRQ_MAX) begin : g_bad_irq
      $error("pm_wake_enc: N_IRQ out of range");
   end
   if (N_PERI < 1 || N_PERI > PERI_MAX) begin : g_bad_peri
      $error("pm_wake_enc: N_PERI out of range");
   end
   if (IRL_W < 1 || IRL_W > 4) begin : g_bad_irl
      $error("pm_wake_enc: IRL_W out of range");
   end

   logic               irq_any, peri_any, irl_any;
   logic [WCODE_W-1:0] irq_code, peri_code, irl_code;

   assign irq_any  = |irq;
   assign peri_any = |peri_irq;
   assign irl_any  = |irl;
   assign irl_code = WC_IRL_BASE | WCODE_W'(irl);

   // lowest index wins: scan downward, last hit overwrites
   always_comb begin
      irq_code = WC_IRQ_BASE;
      for (int i = N_IRQ - 1; i >= 0; i--) begin
         if (irq[i]) irq_code = WC_IRQ_BASE + WCODE_W'(i);
      end
   end

   always_comb begin
      peri_code = WC_PERI_BASE;
      for (int j = N_PERI - 1; j >= 0; j--) begin
         if (peri_irq[j]) peri_code = WC_PERI_BASE + WCODE_W'(j);
      end
   end

   assign req = nmi | irl_any | irq_any | peri_any | port_irq;

   always_comb begin
      if (nmi)           code = WC_NMI;
      else if (irl_any)  code = irl_code;
      else if (irq_any)  code = irq_code;
      else if (peri_any) code = peri_code;
      else if (port_irq) code = WC_PORT;
      else               code = '0;
   end

endmodule

// File: rtl/pm_settle_cnt.sv
module pm_settle_cnt #(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         por_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic         done
);

   if (W < 1) begin : g_bad_w
      $error("pm_settle_cnt: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                   cnt_q <= '0;
      else if (clr)                 cnt_q <= '0;
      else if (load)                cnt_q <= ld_val;
      else if (dec && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/pm_out_dec.sv
module pm_out_dec
   import pm_pkg::*;
(
   input  pm_mode_e   mode,
   output logic       cpu_halt,
   output logic       pclk_en,
   output logic       ckout_en,
   output logic [1:0] stat
);

   always_comb begin
      unique case (mode)
         PM_RUN: begin
            cpu_halt = 1'b0; pclk_en = 1'b1; ckout_en = 1'b1; stat = STAT_RUN;
         end
         PM_SLEEP: begin
            cpu_halt = 1'b1; pclk_en = 1'b1; ckout_en = 1'b1; stat = STAT_SLEEP;
         end
         default: begin
            cpu_halt = 1'b1; pclk_en = 1'b0; ckout_en = 1'b0; stat = STAT_STBY;
         end
      endcase
   end

endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
   import pm_pkg::*;
#(
   parameter int N_IRQ    = 8,
   parameter int N_PERI   = 16,
   parameter int IRL_W    = 4,
   parameter int SETTLE_W = 16
)(
   input  logic                clk,
   input  logic                por_n,
   input  logic                man_rst,
   input  logic                sleep_exec,
   input  logic                sel_we,
   input  logic                sel_d,
   input  logic [SETTLE_W-1:0] settle_cyc,
   input  logic                intr_blk,
   input  logic                nmi,
   input  logic [N_IRQ-1:0]    irq,
   input  logic [IRL_W-1:0]    irl,
   input  logic [N_PERI-1:0]   peri_irq,
   input  logic                port_irq,
   output logic                cpu_halt,
   output logic                pclk_en,
   output logic                ckout_en,
   output logic [1:0]          stat_pins,
   output logic                wake_vld,
   output logic [WCODE_W-1:0]  wake_code,
   output logic                pinit_pulse,
   output logic                stby_sel
);

   // wake-up is accepted whatever the block-interrupts bit says
   logic unused_intr_blk;
   assign unused_intr_blk = intr_blk;

   pm_mode_e           mode_q;
   logic               req;
   logic [WCODE_W-1:0] req_code, held_code_q;
   logic               settle_done, settle_load;

   pm_wake_enc #(.N_IRQ(N_IRQ), .N_PERI(N_PERI), .IRL_W(IRL_W)) i_enc (
      .nmi      (nmi),
      .irq      (irq),
      .irl      (irl),
      .peri_irq (peri_irq),
      .port_irq (port_irq),
      .req      (req),
      .code     (req_code)
   );

   assign settle_load = (mode_q == PM_STBY) && req && !man_rst;

   pm_settle_cnt #(.W(SETTLE_W)) i_settle (
      .clk    (clk),
      .por_n  (por_n),
      .clr    (man_rst),
      .load   (settle_load),
      .ld_val (settle_cyc),
      .dec    (mode_q == PM_SETTLE),
      .done   (settle_done)
   );

   pm_out_dec i_dec (
      .mode     (mode_q),
      .cpu_halt (cpu_halt),
      .pclk_en  (pclk_en),
      .ckout_en (ckout_en),
      .stat     (stat_pins)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q      <= PM_RUN;
         stby_sel    <= 1'b0;
         wake_vld    <= 1'b0;
         wake_code   <= '0;
         held_code_q <= '0;
         pinit_pulse <= 1'b0;
      end else begin
         wake_vld    <= 1'b0;
         pinit_pulse <= 1'b0;
         if (sel_we) stby_sel <= sel_d;
         if (man_rst) begin
            mode_q <= PM_RUN;
         end else begin
            unique case (mode_q)
               PM_RUN: begin
                  if (sleep_exec) begin
                     if (stby_sel) begin
                        mode_q      <= PM_STBY;
                        pinit_pulse <= 1'b1;
                     end else begin
                        mode_q <= PM_SLEEP;
                     end
                  end
               end
               PM_SLEEP: begin
                  if (req) begin
                     mode_q    <= PM_RUN;
                     wake_vld  <= 1'b1;
                     wake_code <= req_code;
                  end
               end
               PM_STBY: begin
                  if (req) begin
                     mode_q      <= PM_SETTLE;
                     held_code_q <= req_code;
                  end
               end
               PM_SETTLE: begin
                  if (settle_done) begin
                     mode_q    <= PM_RUN;
                     wake_vld  <= 1'b1;
                     wake_code <= held_code_q;
                  end
               end
               default: mode_q <= PM_RUN;
            endcase
         end
      end
   end

endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk #(
   parameter int N_IRQ  = 8,
   parameter int N_PERI = 16,
   parameter int IRL_W  = 4
)(
   input logic              clk,
   input logic              por_n,
   input logic              man_rst,
   input logic              sleep_exec,
   input logic              stby_sel,
   input logic              nmi,
   input logic [N_IRQ-1:0]  irq,
   input logic [IRL_W-1:0]  irl,
   input logic [N_PERI-1:0] peri_irq,
   input logic              port_irq,
   input logic              cpu_halt,
   input logic              pclk_en,
   input logic              ckout_en,
   input logic [1:0]        stat_pins,
   input logic              wake_vld,
   input logic              pinit_pulse
);

   logic any_req;
   assign any_req = nmi | (|irq) | (|irl) | (|peri_irq) | port_irq;

   a_r1_sleep_entry: assert property (@(posedge clk) disable iff (!por_n)
      (stat_pins == 2'b00 && sleep_exec && !stby_sel && !man_rst)
      |=> (stat_pins == 2'b10 && cpu_halt));

   a_r2_sleep_clocks: assert property (@(posedge clk) disable iff (!por_n)
      (stat_pins == 2'b10) |-> (pclk_en && ckout_en && cpu_halt));

   a_r3_run_outputs: assert property (@(posedge clk) disable iff (!por_n)
      (stat_pins == 2'b00) |-> (!cpu_halt && pclk_en && ckout_en));

   a_r4_sleep_wake: assert property (@(posedge clk) disable iff (!por_n)
      (stat_pins == 2'b10 && any_req && !man_rst)
      |=> (wake_vld && stat_pins == 2'b00));

   a_r4_wake_once: assert property (@(posedge clk) disable iff (!por_n)
      wake_vld |=> !wake_vld);

   a_r6_stby_clocks: assert property (@(posedge clk) disable iff (!por_n)
      (stat_pins == 2'b11) |-> (!pclk_en && !ckout_en && cpu_halt));

   a_r6_pinit_entry: assert property (@(posedge clk) disable iff (!por_n)
      pinit_pulse |-> (stat_pins == 2'b11 && $past(stat_pins) == 2'b00));

   a_r8_sleep_holds: assert property (@(posedge clk) disable iff (!por_n)
      (stat_pins == 2'b10 && !any_req && !man_rst) |=> (stat_pins == 2'b10));

   a_r9_manual_reset: assert property (@(posedge clk) disable iff (!por_n)
      man_rst |=> (stat_pins == 2'b00 && !wake_vld));

   a_r10_por_clears: assert property (@(posedge clk)
      !por_n |-> (stat_pins == 2'b00 && !stby_sel));

endmodule

bind pm_power_ctrl pm_power_ctrl_chk #(
   .N_IRQ(N_IRQ), .N_PERI(N_PERI), .IRL_W(IRL_W)
) i_chk (
   .clk(clk), .por_n(por_n), .man_rst(man_rst), .sleep_exec(sleep_exec),
   .stby_sel(stby_sel), .nmi(nmi), .irq(irq), .irl(irl),
   .peri_irq(peri_irq), .port_irq(port_irq), .cpu_halt(cpu_halt),
   .pclk_en(pclk_en), .ckout_en(ckout_en), .stat_pins(stat_pins),
   .wake_vld(wake_vld), .pinit_pulse(pinit_pulse)
);

// File: tb/test_pm_power_ctrl.sv
module test_pm_power_ctrl;

   localparam int N_IRQ = 8, N_PERI = 16, IRL_W = 4, SW = 16;

   logic clk = 1'b0;
   logic por_n = 1'b0, man_rst = 1'b0, sleep_exec = 1'b0;
   logic sel_we = 1'b0, sel_d = 1'b0, intr_blk = 1'b0;
   logic [SW-1:0] settle_cyc = '0;
   logic nmi = 1'b0, port_irq = 1'b0;
   logic [N_IRQ-1:0] irq = '0;
   logic [IRL_W-1:0] irl = '0;
   logic [N_PERI-1:0] peri_irq = '0;
   logic cpu_halt, pclk_en, ckout_en, wake_vld, pinit_pulse, stby_sel;
   logic [1:0] stat_pins;
   logic [7:0] wake_code;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   pm_power_ctrl #(.N_IRQ(N_IRQ), .N_PERI(N_PERI), .IRL_W(IRL_W), .SETTLE_W(SW))
   i_pm_power_ctrl (
      .clk(clk), .por_n(por_n), .man_rst(man_rst), .sleep_exec(sleep_exec),
      .sel_we(sel_we), .sel_d(sel_d), .settle_cyc(settle_cyc), .intr_blk(intr_blk),
      .nmi(nmi), .irq(irq), .irl(irl), .peri_irq(peri_irq), .port_irq(port_irq),
      .cpu_halt(cpu_halt), .pclk_en(pclk_en), .ckout_en(ckout_en),
      .stat_pins(stat_pins), .wake_vld(wake_vld), .wake_code(wake_code),
      .pinit_pulse(pinit_pulse), .stby_sel(stby_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // packed outputs: {halt, pclk, ckout, stat[1:0]}
   function automatic logic [4:0] outs();
      return {cpu_halt, pclk_en, ckout_en, stat_pins};
   endfunction

   localparam logic [4:0] O_RUN = 5'b01100, O_SLP = 5'b11110, O_STB = 5'b10011;

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic enter_low();
      sleep_exec = 1'b1; tick(); sleep_exec = 1'b0;
   endtask

   // driver: one-cycle request, expected code into the scoreboard
   task automatic fire(input logic n, input logic [N_IRQ-1:0] q, input logic [IRL_W-1:0] l,
                       input logic [N_PERI-1:0] p, input logic pt, input logic [7:0] exp);
      nmi = n; irq = q; irl = l; peri_irq = p; port_irq = pt;
      exp_q.push_back(exp);
      tick();
      nmi = 1'b0; irq = '0; irl = '0; peri_irq = '0; port_irq = 1'b0;
   endtask

   // monitor: compare every wake strobe against the scoreboard
   always @(negedge clk) begin
      if (por_n && wake_vld) begin
         if (exp_q.size() == 0) chk("R4 unexpected wake", 32'(wake_code), 32'hFFFF);
         else chk("R5 wake code", 32'(wake_code), 32'(exp_q.pop_front()));
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick();
      chk("R3 reset outputs", 32'(outs()), 32'(O_RUN));
      chk("R10 reset sel", 32'(stby_sel), 0);
      chk("R3 reset strobes", 32'({wake_vld, pinit_pulse}), 0);
      por_n = 1'b1; tick(); tick();

      // R1 / R2 sleep entry
      enter_low();
      chk("R1 sleep entry", 32'(outs()), 32'(O_SLP));
      tick();
      chk("R2 sleep clocks stay on", 32'(outs()), 32'(O_SLP));

      // R8 sleep pulse ignored in sleep
      enter_low();
      chk("R8 sleep pulse ignored", 32'(outs()), 32'(O_SLP));

      // R4 wake with interrupts blocked
      intr_blk = 1'b1;
      fire(1'b0, 8'h04, '0, '0, 1'b0, 8'h22);
      chk("R4 back to run", 32'(outs()), 32'(O_RUN));
      chk("R4 strobe high", 32'(wake_vld), 1);
      tick();
      chk("R4 strobe one cycle", 32'(wake_vld), 0);

      // R5 priority cases
      enter_low(); fire(1'b0, 8'hA0, '0, 16'h0008, 1'b1, 8'h25); tick();
      enter_low(); fire(1'b0, 8'h01, 4'd9, 16'h0001, 1'b0, 8'h19); tick();
      enter_low(); fire(1'b1, 8'hFF, 4'd3, 16'hFFFF, 1'b1, 8'h01); tick();
      enter_low(); fire(1'b0, '0, '0, 16'h8001, 1'b0, 8'h40); tick();
      enter_low(); fire(1'b0, '0, '0, '0, 1'b1, 8'h80); tick();
      intr_blk = 1'b0;
      chk("R5 queue drained", 32'(exp_q.size()), 0);

      // R11 select write
      sel_d = 1'b1; sel_we = 1'b1; tick(); sel_we = 1'b0;
      chk("R11 select bit", 32'(stby_sel), 1);

      // R6 standby entry
      settle_cyc = 16'd3;
      enter_low();
      chk("R6 standby outputs", 32'(outs()), 32'(O_STB));
      chk("R6 init pulse", 32'(pinit_pulse), 1);
      tick();
      chk("R6 init pulse one cycle", 32'(pinit_pulse), 0);
      enter_low();
      chk("R8 standby holds", 32'(outs()), 32'(O_STB));
      chk("R8 no init on ignored pulse", 32'(pinit_pulse), 0);

      // R7 settle wait of 3+1 cycles
      fire(1'b0, '0, '0, 16'h0002, 1'b0, 8'h41);
      for (int k = 0; k <= 3; k++) begin
         chk("R7 settling", 32'(outs()), 32'(O_STB));
         chk("R7 no early strobe", 32'(wake_vld), 0);
         tick();
      end
      chk("R7 run after settle", 32'(outs()), 32'(O_RUN));
      chk("R7 strobe after settle", 32'(wake_vld), 1);
      tick();

      // R7 zero settle
      settle_cyc = '0;
      enter_low();
      fire(1'b0, 8'h80, '0, '0, 1'b0, 8'h27);
      chk("R7 zero settle one cycle", 32'(outs()), 32'(O_STB));
      tick();
      chk("R7 zero settle run", 32'(outs()), 32'(O_RUN));
      tick();

      // R9 manual reset from standby
      enter_low();
      man_rst = 1'b1; tick(); man_rst = 1'b0;
      chk("R9 run after manual reset", 32'(outs()), 32'(O_RUN));
      chk("R9 no strobe", 32'(wake_vld), 0);
      chk("R9 select kept", 32'(stby_sel), 1);

      // R9 manual reset from sleep
      sel_d = 1'b0; sel_we = 1'b1; tick(); sel_we = 1'b0;
      enter_low();
      chk("R1 sleep again", 32'(outs()), 32'(O_SLP));
      man_rst = 1'b1; tick(); man_rst = 1'b0;
      chk("R9 sleep to run", 32'(outs()), 32'(O_RUN));
      chk("R9 no strobe from sleep", 32'(wake_vld), 0);

      // R10 asynchronous power-on reset during standby
      sel_d = 1'b1; sel_we = 1'b1; tick(); sel_we = 1'b0;
      enter_low();
      chk("R6 standby before POR", 32'(stat_pins), 32'(2'b11));
      #2 por_n = 1'b0; #1;
      chk("R10 async run", 32'(outs()), 32'(O_RUN));
      chk("R10 select cleared", 32'(stby_sel), 0);
      tick(); por_n = 1'b1; tick();
      chk("R4 no stray wakes", 32'(exp_q.size()), 0);
      finish_run();
   end

endmodule